// File: doc/BRIEF.md
# Line Transfer and Exposure Sequencer

This block runs the per-line control cycle of a linear photodiode array. A line trigger starts a line. The block first counts an integration interval. It then moves the collected charge into the readout register by nesting a photo-gate pulse inside a transfer-gate pulse. Last, it hands the readout register back to the readout clock generator after a programmable settling delay. A handshake with that generator makes sure the horizontal clocks are parked before the transfer gate opens: a halt request goes out, and a parked acknowledge comes back.

An electronic shutter is built from the antiblooming gate. During the early part of the integration interval the gate drains the photodiodes. It drops a programmable number of cycles before the transfer, so only the last part of the interval collects charge. All line settings are captured when the trigger is accepted, so an update written during a line affects only a later line. A trigger that arrives while a line is still running is discarded and latches an overrun flag.

Top module: `line_xfer_seq`

## Requirements
- R1: After reset, the halt request, the transfer gate, the photo gate, the antiblooming gate and the overrun flag are all low.
- R2: The halt request rises in the cycle after an accepted trigger and stays high until the restart delay has elapsed. It is high whenever the transfer gate is high.
- R3: The integration interval lasts P cycles, where P is the period setting and a value of 0 counts as 1. The transfer gate rises in the first cycle after integration ends if the parked input is high. Otherwise it rises in the cycle after the parked input is first seen high, and never without it.
- R4: The photo gate rises one cycle after the transfer gate rises and stays high for W cycles, where W is the photo-gate width setting and 0 counts as 1. It is never high while the transfer gate is low.
- R5: The photo gate falls first. The transfer gate falls H cycles later, where H is the hold setting and 0 counts as 1.
- R6: With exposure setting E < P, the antiblooming gate is high for the first P-E integration cycles. It falls exactly E cycles before the transfer gate rises when no parking wait occurs, and E = 0 keeps it high for all P cycles. With E >= P it stays low for the whole line. It is low outside integration.
- R7: The halt request falls R cycles after the transfer gate falls, where R is the restart setting and 0 counts as 1. The block then accepts a new trigger.
- R8: All five settings are sampled in the cycle the trigger is accepted. Changes made during a running line do not alter that line.
- R9: A trigger that arrives while a line is running does not change the line's timing. It sets the overrun flag, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_trig_i | input | 1 | Starts a line when the block is idle |
| cfg_period_i | input | 16 | Integration interval P in cycles |
| cfg_expose_i | input | 16 | Exposure length E in cycles |
| cfg_pg_width_i | input | 16 | Photo-gate high time W in cycles |
| cfg_tg_hold_i | input | 16 | Transfer-gate hold after photo-gate fall, H cycles |
| cfg_restart_i | input | 16 | Readout restart delay R in cycles |
| rdo_parked_i | input | 1 | Readout clocks parked, phase 1 high and phase 2 low |
| rdo_halt_o | output | 1 | Request to stop and hold the readout clocks |
| tg_o | output | 1 | Transfer gate |
| pg_o | output | 1 | Photo gate |
| ab_o | output | 1 | Antiblooming gate |
| overrun_o | output | 1 | Sticky flag for a trigger during a running line |

## Verification
The bench targets the exposure boundaries: E = 0, E = P and E > P. A wrong compare in the shutter logic would show up here as an antiblooming pulse one cycle too long, a spurious pulse, or no drain at all. Zero-valued widths are driven to catch a counter that wraps and produces a pulse thousands of cycles long. A late parked acknowledge is used to catch a transfer gate that opens on a running register. Two more cases look for leaks of the next line's settings into the current one: settings rewritten mid-line, and a retrigger mid-line. A faulty design would stretch or restart the gate sequence, or fail to latch the overrun flag.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
    parameter int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTEG,
        ST_PARK,
        ST_TG_LEAD,
        ST_PG_HOLD,
        ST_TG_TAIL,
        ST_RESTART
    } seq_state_e;

    typedef struct packed {
        cnt_t period;
        cnt_t expose;
        cnt_t pg_width;
        cnt_t tg_tail;
        cnt_t restart;
    } line_cfg_t;

    function automatic cnt_t at_least_one(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction
endpackage

// File: rtl/lxs_cfg_shadow.sv
module lxs_cfg_shadow
    import lxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  line_cfg_t cfg_in,
    output line_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.period   <= cnt_t'(1);
            cfg_q.expose   <= '0;
            cfg_q.pg_width <= cnt_t'(1);
            cfg_q.tg_tail  <= cnt_t'(1);
            cfg_q.restart  <= cnt_t'(1);
        end else if (load) begin
            cfg_q.period   <= at_least_one(cfg_in.period);
            cfg_q.expose   <= cfg_in.expose;
            cfg_q.pg_width <= at_least_one(cfg_in.pg_width);
            cfg_q.tg_tail  <= at_least_one(cfg_in.tg_tail);
            cfg_q.restart  <= at_least_one(cfg_in.restart);
        end
    end
endmodule

// File: rtl/lxs_fsm.sv
module lxs_fsm
    import lxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       parked,
    input  cnt_t       period,
    input  cnt_t       pg_width,
    input  cnt_t       tg_tail,
    input  cnt_t       restart,
    output seq_state_e state,
    output cnt_t       cnt,
    output logic       accept,
    output logic       overrun
);
    seq_state_e state_n;
    cnt_t       cnt_n;
    logic       last;

    assign accept = (state == ST_IDLE) && trig;

    always_comb begin
        state_n = state;
        cnt_n   = cnt + cnt_t'(1);
        last    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (trig) state_n = ST_INTEG;
            end
            ST_INTEG: begin
                last = (cnt == period - cnt_t'(1));
                if (last) begin
                    state_n = parked ? ST_TG_LEAD : ST_PARK;
                    cnt_n   = '0;
                end
            end
            ST_PARK: begin
                cnt_n = '0;
                if (parked) state_n = ST_TG_LEAD;
            end
            ST_TG_LEAD: begin
                state_n = ST_PG_HOLD;
                cnt_n   = '0;
            end
            ST_PG_HOLD: begin
                last = (cnt == pg_width - cnt_t'(1));
                if (last) begin
                    state_n = ST_TG_TAIL;
                    cnt_n   = '0;
                end
            end
            ST_TG_TAIL: begin
                last = (cnt == tg_tail - cnt_t'(1));
                if (last) begin
                    state_n = ST_RESTART;
                    cnt_n   = '0;
                end
            end
            ST_RESTART: begin
                last = (cnt == restart - cnt_t'(1));
                if (last) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (trig && (state != ST_IDLE)) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/lxs_gate_decode.sv
module lxs_gate_decode
    import lxs_pkg::*;
(
    input  seq_state_e state,
    input  cnt_t       cnt,
    input  cnt_t       period,
    input  cnt_t       expose,
    output logic       halt,
    output logic       tg,
    output logic       pg,
    output logic       ab
);
    logic shutter_open_window;

    assign shutter_open_window = (expose < period) && (cnt < (period - expose));

    always_comb begin
        halt = (state != ST_IDLE);
        tg   = (state == ST_TG_LEAD) || (state == ST_PG_HOLD) || (state == ST_TG_TAIL);
        pg   = (state == ST_PG_HOLD);
        ab   = (state == ST_INTEG) && shutter_open_window;
    end
endmodule

// File: rtl/line_xfer_seq.sv
module line_xfer_seq
    import lxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_trig_i,
    input  logic [CNT_W-1:0] cfg_period_i,
    input  logic [CNT_W-1:0] cfg_expose_i,
    input  logic [CNT_W-1:0] cfg_pg_width_i,
    input  logic [CNT_W-1:0] cfg_tg_hold_i,
    input  logic [CNT_W-1:0] cfg_restart_i,
    input  logic             rdo_parked_i,
    output logic             rdo_halt_o,
    output logic             tg_o,
    output logic             pg_o,
    output logic             ab_o,
    output logic             overrun_o
);
    line_cfg_t  cfg_live;
    line_cfg_t  cfg_line;
    seq_state_e state;
    cnt_t       cnt;
    logic       accept;

    assign cfg_live = '{period:   cfg_period_i,
                        expose:   cfg_expose_i,
                        pg_width: cfg_pg_width_i,
                        tg_tail:  cfg_tg_hold_i,
                        restart:  cfg_restart_i};

    lxs_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_line)
    );

    lxs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trig     (line_trig_i),
        .parked   (rdo_parked_i),
        .period   (cfg_line.period),
        .pg_width (cfg_line.pg_width),
        .tg_tail  (cfg_line.tg_tail),
        .restart  (cfg_line.restart),
        .state    (state),
        .cnt      (cnt),
        .accept   (accept),
        .overrun  (overrun_o)
    );

    lxs_gate_decode u_dec (
        .state  (state),
        .cnt    (cnt),
        .period (cfg_line.period),
        .expose (cfg_line.expose),
        .halt   (rdo_halt_o),
        .tg     (tg_o),
        .pg     (pg_o),
        .ab     (ab_o)
    );
endmodule

// File: rtl/line_xfer_seq_chk.sv
module line_xfer_seq_chk (
    input logic clk,
    input logic rst,
    input logic rdo_parked_i,
    input logic rdo_halt_o,
    input logic tg_o,
    input logic pg_o,
    input logic ab_o,
    input logic overrun_o
);
    // R3
    tg_needs_park_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tg_o) |-> $past(rdo_parked_i));

    // R4
    pg_after_tg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_o) |-> $past(tg_o));

    // R5
    tg_falls_after_pg_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tg_o) |-> $past(!pg_o));

    // R2
    halt_covers_tg_chk: assert property (@(posedge clk) disable iff (rst)
        tg_o |-> rdo_halt_o);

    // R7
    halt_drop_after_tg_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdo_halt_o) |-> (!tg_o && $past(!tg_o)));

    // R6
    ab_off_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        ab_o |-> (!tg_o && !pg_o));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

bind line_xfer_seq line_xfer_seq_chk u_lxs_chk (
    .clk          (clk),
    .rst          (rst),
    .rdo_parked_i (rdo_parked_i),
    .rdo_halt_o   (rdo_halt_o),
    .tg_o         (tg_o),
    .pg_o         (pg_o),
    .ab_o         (ab_o),
    .overrun_o    (overrun_o)
);

// File: tb/line_xfer_seq_bench.sv
module line_xfer_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [15:0] c_p = 16'd8, c_e = 16'd3, c_w = 16'd2, c_h = 16'd2, c_r = 16'd2;
    logic        parked;
    logic        halt, tg, pg, ab, ovr;
    logic        p1 = 1'b0, p2 = 1'b0, hold = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Readout generator model: parks two cycles after a halt request.
    always_ff @(posedge clk) begin
        p1 <= halt;
        p2 <= p1 & ~hold;
    end
    assign parked = p2;

    line_xfer_seq u_line_xfer_seq (
        .clk(clk), .rst(rst), .line_trig_i(trig),
        .cfg_period_i(c_p), .cfg_expose_i(c_e), .cfg_pg_width_i(c_w),
        .cfg_tg_hold_i(c_h), .cfg_restart_i(c_r), .rdo_parked_i(parked),
        .rdo_halt_o(halt), .tg_o(tg), .pg_o(pg), .ab_o(ab), .overrun_o(ovr)
    );

    function automatic int one_min(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Expected level of each output k cycles after the accepting edge.
    // T is the cycle index where the transfer gate rises.
    function automatic logic [3:0] expect_at(int k, int P, int E, int W, int H, int R, int T);
        logic x_halt, x_tg, x_pg, x_ab;
        x_tg   = (k >= T) && (k < T + 1 + W + H);
        x_pg   = (k >= T + 1) && (k < T + 1 + W);
        x_halt = (k < T + 1 + W + H + R);
        x_ab   = (E < P) && (k < P - E);
        return {x_halt, x_tg, x_pg, x_ab};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_line(input int p, input int e, input int w, input int h, input int r,
                            input int late_k, input int retrig_k, input bit scramble,
                            input string tag);
        int P, W, H, R, T, L;
        int bad [4];
        int bad_k [4];
        int bad_a [4];
        logic [3:0] ex, ac;
        string nm [4];
        nm[0] = "ab"; nm[1] = "pg"; nm[2] = "tg"; nm[3] = "halt";
        for (int i = 0; i < 4; i++) begin bad[i] = 0; bad_k[i] = 0; bad_a[i] = 0; end
        P = one_min(p); W = one_min(w); H = one_min(h); R = one_min(r);
        T = (late_k >= 0) ? late_k + 2 : P;
        L = T + 1 + W + H + R;
        @(negedge clk);
        c_p = 16'(p); c_e = 16'(e); c_w = 16'(w); c_h = 16'(h); c_r = 16'(r);
        hold = (late_k >= 0);
        trig = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= L + 1; k++) begin
            @(negedge clk);
            ex = expect_at(k, P, e, W, H, R, T);
            ac = {halt, tg, pg, ab};
            for (int i = 0; i < 4; i++) begin
                if (ex[i] != ac[i] && bad[i] == 0) begin
                    bad[i] = 1; bad_k[i] = k; bad_a[i] = int'(ac[i]);
                end
            end
            trig = (k == retrig_k);
            if (scramble && k == 1) begin
                c_p = 16'($urandom_range(1, 60)); c_e = 16'($urandom_range(0, 60));
                c_w = 16'($urandom_range(0, 9));  c_h = 16'($urandom_range(0, 9));
                c_r = 16'($urandom_range(0, 9));
            end
            if (k == late_k) hold = 1'b0;
        end
        trig = 1'b0;
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (bad[i] != 0) begin
                fails++;
                $display("FAIL %s %s at k=%0d actual=%0d expected=%0d", tag, nm[i],
                         bad_k[i], bad_a[i], 1 - bad_a[i]);
            end
        end
    endtask

    initial begin
        @(posedge clk);
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "halt", int'(halt), 0);
        check("R1", "tg", int'(tg), 0);
        check("R1", "pg", int'(pg), 0);
        check("R1", "ab", int'(ab), 0);
        check("R1", "overrun", int'(ovr), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R6 nominal and exposure boundaries; R2 R3 R4 R5 R7 timing
        run_line(12, 4, 3, 2, 2, -1, -1, 1'b0, "R6_nominal");
        run_line(10, 0, 2, 2, 2, -1, -1, 1'b0, "R6_zero_exposure");
        run_line(10, 10, 2, 2, 2, -1, -1, 1'b0, "R6_exposure_eq_period");
        run_line(9, 40, 2, 2, 2, -1, -1, 1'b0, "R6_exposure_gt_period");
        run_line(8, 7, 2, 1, 1, -1, -1, 1'b0, "R6_one_cycle_drain");
        // R4 R5 R7 zero settings count as one
        run_line(6, 2, 0, 0, 0, -1, -1, 1'b0, "R4_R5_R7_zero_widths");
        run_line(7, 3, 5, 4, 6, -1, -1, 1'b0, "R2_R5_R7_long_widths");
        // R3 late parked acknowledge
        run_line(6, 2, 2, 2, 2, 11, -1, 1'b0, "R3_late_park");
        // R8 settings rewritten mid-line
        run_line(14, 5, 3, 2, 3, -1, -1, 1'b1, "R8_midline_update");
        repeat (3) @(negedge clk);
        check("R9", "overrun before retrigger", int'(ovr), 0);

        // R9 retrigger during a line: timing unchanged, flag set
        run_line(10, 3, 2, 2, 2, -1, 5, 1'b0, "R9_retrigger");
        check("R9", "overrun after retrigger", int'(ovr), 1);

        // Random lines; R8 scrambling on some of them
        for (int n = 0; n < 40; n++) begin
            int gap;
            gap = $urandom_range(0, 3);
            repeat (gap) @(negedge clk);
            run_line($urandom_range(4, 40), $urandom_range(0, 45), $urandom_range(0, 6),
                     $urandom_range(0, 5), $urandom_range(0, 5), -1, -1,
                     1'($urandom_range(0, 1)), "R3_R6_random");
        end
        check("R9", "overrun still set", int'(ovr), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule